// File: doc/BRIEF.md
# Rising-Edge Event Counter Peripheral

This peripheral counts rising transitions on one asynchronous input line, for example the pulse output of a wheel rotary encoder. Software reads the running total and controls the core through a small word-addressed register bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data.

Two registers are decoded. The control/status word sits at byte offset 0x00 and the read-only total sits at offset 0x04. Software sets an enable bit to start counting. It can pulse a clear command to zero the total, or pulse a soft-reset command that returns the core to its power-up state. A sticky error bit reports a counter overflow. When an overflow occurs the total holds at its maximum instead of wrapping.

Top module: `edge_tally_core`

## Requirements
- R1: Control bit 0 (offset 0x00) is a read/write enable. The total advances only while it is 1.
- R2: Writing 1 to control bit 1 sets the total to 0 one clock after the write. The bit drops back by itself and always reads as 0.
- R3: Writing 1 to control bit 2 returns the enable, the error flag and the total to 0 one clock after the write. The bit reads as 0.
- R4: Control bit 16 is a read-only error flag. It sets when an edge arrives while the total is at its all-ones maximum. It then stays set through clears and is removed only by a soft reset or a hardware reset.
- R5: Control bits 31..17 and 15..1 read as 0, whatever value was written to them.
- R6: Offset 0x04 reads the total, zero-extended to 32 bits. Writes to 0x04 do not change it.
- R7: After the hardware reset (rst_n low), both registers read as 0.
- R8: The input passes through a two-flop synchroniser. Each low-to-high transition adds exactly 1 to the total, however many cycles the input stays high.
- R9: At the all-ones maximum, further edges leave the total unchanged.
- R10: A clear that coincides with a counted edge leaves the total at 0. A write with bit 2 set ignores bits 0 and 1 of the same write.
- R11: Read data appears on the clock after the read strobe and holds until the next read. Offsets other than 0x00 and 0x04 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Asynchronous line whose rising edges are counted |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume a single-cycle write strobe, so that a command write is never repeated in the cycle right after it. They also assume that the read strobe is the only cause of a change in read data. The stimulus drives each bus access for exactly one clock, and it holds every input pulse high and low for several cycles so that the synchroniser sees clean levels. A second instance with a 4-bit total reaches the saturation and error cases within a short run. One edge is placed on purpose in the same cycle as a clear command.

// File: rtl/edge_tally_pkg.sv
// Package: shared constants for the edge counter peripheral.
// Assumes byte offsets on a 32-bit word bus.
package edge_tally_pkg;
    localparam int OFS_CTRL   = 'h0;
    localparam int OFS_TOTAL  = 'h4;
    localparam int BIT_ENABLE = 0;
    localparam int BIT_CLEAR  = 1;
    localparam int BIT_SRST   = 2;
    localparam int BIT_ERROR  = 16;
    localparam int BUS_W      = 32;
endpackage

// File: rtl/edge_rise_detect.sv
// Module: synchronises an asynchronous line and flags each low-to-high
// transition for one clock. Assumes the line holds each level for at least
// two clocks.
module edge_rise_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   last_q;

    // Shift the line through the synchroniser chain.
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[SYNC_STAGES-1];
    end

    assign rise = chain[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/tally_counter.sv
// Module: saturating event counter with a sticky overflow flag.
// Assumes soft reset outranks clear, and clear outranks an increment.
module tally_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Update the total and the overflow flag in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (clear) begin
            count    <= '0;
        end else if (inc) begin
            if (count == CNT_MAX) overflow <= 1'b1;
            else                  count    <= count + 1'b1;
        end
    end
endmodule

// File: rtl/tally_regs.sv
// Module: register decode for the control/status word and the total.
// Assumes one-cycle write strobes; command bits live for one clock.
module tally_regs
    import edge_tally_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              overflow,
    output logic              en_bit,
    output logic              clr_cmd,
    output logic              srst_cmd
);
    logic             hit_ctrl;
    logic             hit_total;
    logic [BUS_W-1:0] rd_next;
    logic             wdata_unused;

    assign hit_ctrl     = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_total    = (bus_addr == ADDR_W'(OFS_TOTAL));
    assign wdata_unused = ^bus_wdata;

    // Hold the enable and raise one-clock command strobes from writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bit   <= 1'b0;
            clr_cmd  <= 1'b0;
            srst_cmd <= 1'b0;
        end else begin
            clr_cmd  <= 1'b0;
            srst_cmd <= 1'b0;
            if (srst_cmd) begin
                en_bit <= 1'b0;
            end else if (bus_wr && hit_ctrl) begin
                if (bus_wdata[BIT_SRST]) begin
                    srst_cmd <= 1'b1;
                end else begin
                    en_bit  <= bus_wdata[BIT_ENABLE];
                    clr_cmd <= bus_wdata[BIT_CLEAR];
                end
            end
        end
    end

    // Select the word to return for a read.
    always_comb begin
        rd_next = '0;
        if (hit_ctrl) begin
            rd_next[BIT_ENABLE] = en_bit;
            rd_next[BIT_ERROR]  = overflow;
        end else if (hit_total) begin
            rd_next[CNT_W-1:0]  = count;
        end
    end

    // Register read data on a read strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/edge_tally_core.sv
// Module: top of the rising-edge counter peripheral. It joins the
// synchroniser, the counter and the register decode.
// Assumes CNT_W is at most 32 and ADDR_W is at least 3.
module edge_tally_core
    import edge_tally_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic             rise_evt;
    logic             en_bit;
    logic             clr_cmd;
    logic             srst_cmd;
    logic             err_flag;
    logic [CNT_W-1:0] cnt_value;

    edge_rise_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk(clk), .rst_n(rst_n), .line_in(pulse_in), .rise(rise_evt)
    );

    tally_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .srst(srst_cmd), .clear(clr_cmd),
        .inc(rise_evt & en_bit), .count(cnt_value), .overflow(err_flag)
    );

    tally_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .count(cnt_value), .overflow(err_flag), .en_bit(en_bit),
        .clr_cmd(clr_cmd), .srst_cmd(srst_cmd)
    );
endmodule

// File: rtl/edge_tally_checker.sv
// Module: assertion checker bound to edge_tally_core. It assumes
// one-cycle write strobes.
module edge_tally_checker #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              en_bit,
    input logic              clr_cmd,
    input logic              srst_cmd,
    input logic              err_flag,
    input logic [CNT_W-1:0]  cnt_value
);
    localparam logic [CNT_W-1:0] TOP = '1;
    logic clr_again;
    logic wdata_unused;
    assign clr_again    = bus_wr && (bus_addr == '0) && bus_wdata[1];
    assign wdata_unused = ^bus_wdata;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bit && !clr_cmd && !srst_cmd) |=> $stable(cnt_value)); // R1
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (cnt_value == '0)); // R2
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !clr_again) |=> !clr_cmd); // R2
    AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_cmd |=> (cnt_value == '0 && !err_flag && !en_bit)); // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !srst_cmd) |=> err_flag); // R4
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cmd && !srst_cmd) |=> (cnt_value == $past(cnt_value) ||
                                     cnt_value == $past(cnt_value) + 1'b1)); // R8
    AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value == TOP && !clr_cmd && !srst_cmd) |=> (cnt_value == TOP)); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(4)) |=> (bus_rdata == '0)); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind edge_tally_core edge_tally_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .en_bit(en_bit), .clr_cmd(clr_cmd), .srst_cmd(srst_cmd),
    .err_flag(err_flag), .cnt_value(cnt_value)
);

// File: tb/tb_edge_tally_core.sv
module tb_edge_tally_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pulse_in = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] rdata_main;
    logic [31:0] rdata_small;
    int          checks = 0;
    int          errors = 0;

    typedef struct {
        logic [31:0] exp_main;
        logic [31:0] exp_small;
        bit          chk_small;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    edge_tally_core dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_main)
    );

    edge_tally_core #(.CNT_W(4)) dut_small (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(rdata_small)
    );

    task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: pop expectations as read data comes out.
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11: read data with no expectation, actual 0x%08h expected none", rdata_main);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    compare(rdata_main, it.exp_main, it.tag);
                    if (it.chk_small) compare(rdata_small, it.exp_small, {it.tag, " (4-bit)"});
                end
            end
        end
    end

    task automatic rd_reg(input logic [3:0] a, input logic [31:0] em,
                          input bit cs, input logic [31:0] es, input string tag);
        item_t it;
        @(negedge clk);
        it.exp_main = em; it.exp_small = es; it.chk_small = cs; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pulse_in = 1'b1;
            repeat (3) @(negedge clk);
            pulse_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_reg(4'h0, 32'h0, 1, 32'h0, "R7 control after reset");
        rd_reg(4'h4, 32'h0, 1, 32'h0, "R7 total after reset");

        pulses(3);
        rd_reg(4'h4, 32'h0, 0, 0, "R1 no count while disabled");

        wr_reg(4'h0, 32'hFFFF_FFF9);
        rd_reg(4'h0, 32'h1, 0, 0, "R5 R1 enable set, unused bits zero");

        pulses(5);
        rd_reg(4'h4, 32'd5, 1, 32'd5, "R8 five long pulses counted once each");

        wr_reg(4'h4, 32'h1234);
        rd_reg(4'h4, 32'd5, 0, 0, "R6 write to total ignored");

        wr_reg(4'h0, 32'h3);
        rd_reg(4'h0, 32'h1, 0, 0, "R2 clear bit reads back 0");
        rd_reg(4'h4, 32'h0, 0, 0, "R2 total cleared");

        pulses(2);
        rd_reg(4'h4, 32'd2, 0, 0, "R8 counting resumes after clear");

        // Clear write lands in the same cycle as a counted edge.
        @(negedge clk); pulse_in = 1'b1;
        @(negedge clk); bus_addr = 4'h0; bus_wdata = 32'h3; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        repeat (3) @(negedge clk); pulse_in = 1'b0;
        repeat (4) @(negedge clk);
        rd_reg(4'h4, 32'h0, 0, 0, "R10 clear beats coincident edge");

        rd_reg(4'h8, 32'h0, 1, 32'h0, "R11 unmapped offset reads 0");
        rd_reg(4'hC, 32'h0, 0, 0, "R11 unmapped offset reads 0");

        pulses(2);
        wr_reg(4'h0, 32'h7);
        rd_reg(4'h0, 32'h0, 1, 32'h0, "R3 R10 soft reset drops enable");
        rd_reg(4'h4, 32'h0, 1, 32'h0, "R3 soft reset zeroes total");
        pulses(2);
        rd_reg(4'h4, 32'h0, 0, 0, "R3 disabled after soft reset");

        wr_reg(4'h0, 32'h1);
        pulses(16);
        rd_reg(4'h4, 32'd16, 1, 32'd15, "R9 saturation at maximum");
        rd_reg(4'h0, 32'h1, 1, 32'h0001_0001, "R4 error flag on overflow");

        wr_reg(4'h0, 32'h3);
        rd_reg(4'h0, 32'h1, 1, 32'h0001_0001, "R4 error survives clear");
        pulses(1);
        rd_reg(4'h4, 32'd1, 1, 32'd1, "R2 count after clear with error set");

        wr_reg(4'h0, 32'h4);
        rd_reg(4'h0, 32'h0, 1, 32'h0, "R3 R4 soft reset removes error");
        rd_reg(4'h4, 32'h0, 1, 32'h0, "R3 total zero after soft reset");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R11: %0d reads unanswered, expected 0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule